// File: doc/BRIEF.md
# PID-Tagged Translation Entry Flush Sweeper

This block walks every entry of a two-sided translation buffer (an instruction side and a data side, each set-associative) and finds the entries that belong to one address-space identifier. Software or a control sequencer starts a sweep with a one-cycle command that carries the identifier. The sweeper then reads the entries one at a time through a synchronous read port into the buffer storage. For each valid, non-global entry whose tag matches, it sends out a flush request that carries the page-aligned virtual address of that entry.

Flush requests use a valid/ready stream. The sweeper raises `fl_valid` together with an address and holds both unchanged until `fl_ready` is seen high at a clock edge. While a request is waiting, the sweeper issues no new reads, so back-pressure from the consumer stops the walk without losing an entry. The consumer may hold `fl_ready` low for any number of cycles. When every entry has been examined and the last request has been taken, `done` pulses for one cycle and the block returns to idle. Clearing the entries and any effect on caches belong to other logic.

Top module: `tlb_pid_sweeper`

## Requirements
- R1: While reset is held, and at the first clock edge after it, `busy`, `done`, `rd_en` and `fl_valid` are all low.
- R2: A `start` pulse seen while idle begins a sweep, and `busy` is high at the next edge. The identifier is `start_pid[7:0]`. Bits above 7 are ignored.
- R3: Reads are issued only while busy, with `rd_en` high for one address per cycle. The address {`rd_side`,`rd_way`,`rd_idx`} counts up from 0 to 127, so the index (4 bits) is innermost, then the way (2 bits), then the side (1 bit). Each entry is read exactly once. Read data is expected on `rd_hi`/`rd_lo` in the cycle after `rd_en`.
- R4: An entry matches when `rd_lo` bit 3 (valid) is 1, `rd_lo` bit 4 (global) is 0, and `rd_hi[7:0]` equals the identifier. Invalid entries and global entries produce no flush.
- R5: Each flush address is `rd_hi[31:13]` followed by 13 zero bits. Flushes appear in sweep order, one per matching entry.
- R6: `fl_valid` and `fl_vaddr` stay unchanged until `fl_ready` is high at an edge. While `fl_valid` is high, `rd_en` stays low.
- R7: A `start` pulse while busy is ignored. The running sweep keeps its identifier and produces a single `done`.
- R8: `done` is high for exactly one cycle per sweep. It comes after the last entry has been examined and the last flush has been accepted. With no matches, `done` is high 130 clock edges after the edge that took `start`.
- R9: `busy` stays high from the edge after the accepted start until the edge that raises `done`, and it is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Sweep command pulse |
| start_pid | input | 32 | Identifier to match; only bits 7:0 are used |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| rd_en | output | 1 | Entry read strobe |
| rd_side | output | 1 | Buffer side of the read |
| rd_way | output | 2 | Way of the read |
| rd_idx | output | 4 | Index of the read |
| rd_hi | input | 32 | Entry tag word, one cycle after `rd_en` |
| rd_lo | input | 32 | Entry attribute word, one cycle after `rd_en` |
| fl_valid | output | 1 | Flush request valid |
| fl_ready | input | 1 | Flush request accepted by consumer |
| fl_vaddr | output | 32 | Page-aligned virtual address to flush |

## Verification
The bench builds the block with its defaults: 2 sides, 4 ways, 16 indices, an 8-bit identifier, 32-bit words and 13-bit pages. With these values a full sweep is 128 reads. That keeps the side rollover (address 63 to 64), the exact 130-edge length of a sweep with no matches, and back-pressure with the consumer accepting one cycle in three all within a few hundred cycles per case. The storage pattern mixes identifiers, global flags and valid flags so that each of them blocks some entries whose tag does match.

// File: rtl/tlbsw_pkg.sv
package tlbsw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } sweep_state_e;

  // attribute-word bit positions decoded by the match stage
  localparam int ATTR_VALID_BIT  = 3;
  localparam int ATTR_GLOBAL_BIT = 4;
endpackage

// File: rtl/tlbsw_walker.sv
module tlbsw_walker #(
  parameter int SIDES = 2,
  parameter int WAYS  = 4,
  parameter int SLOTS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic [((SIDES > 1) ? $clog2(SIDES) : 1)-1:0] side,
  output logic [((WAYS  > 1) ? $clog2(WAYS)  : 1)-1:0] way,
  output logic [((SLOTS > 1) ? $clog2(SLOTS) : 1)-1:0] idx,
  output logic last
);
  localparam int SIDE_W = (SIDES > 1) ? $clog2(SIDES) : 1;
  localparam int WAY_W  = (WAYS  > 1) ? $clog2(WAYS)  : 1;
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W  = SIDE_W + WAY_W + IDX_W;
  localparam int TOTAL  = SIDES * WAYS * SLOTS;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (step)       cnt_q <= cnt_q + 1'b1;
  end

  // index is the low field so it turns fastest, side the high field
  assign idx  = cnt_q[IDX_W-1:0];
  assign way  = cnt_q[IDX_W +: WAY_W];
  assign side = cnt_q[IDX_W + WAY_W +: SIDE_W];
  assign last = (cnt_q == CNT_W'(TOTAL - 1));
endmodule

// File: rtl/tlbsw_match.sv
module tlbsw_match
  import tlbsw_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int PID_W      = 8,
  parameter int PAGE_SHIFT = 13
) (
  input  logic              en,
  input  logic [WORD_W-1:0] tag_word,
  input  logic [WORD_W-1:0] attr_word,
  input  logic [PID_W-1:0]  pid,
  output logic              hit,
  output logic [WORD_W-1:0] page_addr
);
  logic unused_bits;

  assign hit = en
             && attr_word[ATTR_VALID_BIT]
             && !attr_word[ATTR_GLOBAL_BIT]
             && (tag_word[PID_W-1:0] == pid);

  assign page_addr = {tag_word[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

  assign unused_bits = ^{tag_word[PAGE_SHIFT-1:PID_W], attr_word};
endmodule

// File: rtl/tlbsw_flush_slot.sv
module tlbsw_flush_slot #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_pid_sweeper.sv
module tlb_pid_sweeper
  import tlbsw_pkg::*;
#(
  parameter int SIDES      = 2,
  parameter int WAYS       = 4,
  parameter int SLOTS      = 16,
  parameter int PID_W      = 8,
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         start,
  input  logic [WORD_W-1:0]                            start_pid,
  output logic                                         busy,
  output logic                                         done,
  output logic                                         rd_en,
  output logic [((SIDES > 1) ? $clog2(SIDES) : 1)-1:0] rd_side,
  output logic [((WAYS  > 1) ? $clog2(WAYS)  : 1)-1:0] rd_way,
  output logic [((SLOTS > 1) ? $clog2(SLOTS) : 1)-1:0] rd_idx,
  input  logic [WORD_W-1:0]                            rd_hi,
  input  logic [WORD_W-1:0]                            rd_lo,
  output logic                                         fl_valid,
  input  logic                                         fl_ready,
  output logic [WORD_W-1:0]                            fl_vaddr
);
  localparam int SIDE_W = (SIDES > 1) ? $clog2(SIDES) : 1;
  localparam int WAY_W  = (WAYS  > 1) ? $clog2(WAYS)  : 1;
  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int ADDR_W = SIDE_W + WAY_W + IDX_W;

  sweep_state_e      state_q;
  logic [PID_W-1:0]  pid_q;
  logic              rd_pend_q;
  logic              done_q;
  logic              accept;
  logic              issue;
  logic              at_last;
  logic              hit;
  logic [WORD_W-1:0] hit_addr;
  logic              unused_pid_hi;

  assign accept = (state_q == ST_IDLE) && start;

  // A read is sent only when its result can be stored next cycle:
  // the slot is empty and no hit is being loaded into it now.
  assign issue = (state_q == ST_SCAN) && !fl_valid && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pid_q     <= '0;
      rd_pend_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      rd_pend_q <= issue;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            pid_q   <= start_pid[PID_W-1:0];
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (issue && at_last) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!rd_pend_q && !fl_valid) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  tlbsw_walker #(
    .SIDES (SIDES),
    .WAYS  (WAYS),
    .SLOTS (SLOTS)
  ) u_walker (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (issue),
    .side  (rd_side),
    .way   (rd_way),
    .idx   (rd_idx),
    .last  (at_last)
  );

  tlbsw_match #(
    .WORD_W     (WORD_W),
    .PID_W      (PID_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_match (
    .en        (rd_pend_q),
    .tag_word  (rd_hi),
    .attr_word (rd_lo),
    .pid       (pid_q),
    .hit       (hit),
    .page_addr (hit_addr)
  );

  tlbsw_flush_slot #(
    .WORD_W (WORD_W)
  ) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hit),
    .din   (hit_addr),
    .ready (fl_ready),
    .valid (fl_valid),
    .dout  (fl_vaddr)
  );

  assign rd_en = issue;
  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;

  assign unused_pid_hi = ^start_pid[WORD_W-1:PID_W];
endmodule

// File: rtl/tlb_pid_sweeper_chk.sv
module tlb_pid_sweeper_chk #(
  parameter int ADDR_W     = 7,
  parameter int WORD_W     = 32,
  parameter int PAGE_SHIFT = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              fl_valid,
  input logic              fl_ready,
  input logic [WORD_W-1:0] fl_vaddr
);
  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_read_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  p_read_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

  p_page_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> (fl_vaddr[PAGE_SHIFT-1:0] == '0));

  p_hold_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_ready) |=> (fl_valid && $stable(fl_vaddr)));

  p_no_read_while_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> !rd_en);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind tlb_pid_sweeper tlb_pid_sweeper_chk #(
  .ADDR_W     (ADDR_W),
  .WORD_W     (WORD_W),
  .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .rd_en    (rd_en),
  .rd_addr  ({rd_side, rd_way, rd_idx}),
  .fl_valid (fl_valid),
  .fl_ready (fl_ready),
  .fl_vaddr (fl_vaddr)
);

// File: tb/tlb_pid_sweeper_tb_top.sv
`timescale 1ns/1ps
module tlb_pid_sweeper_tb_top;
  localparam int N = 128;
  // scenario: {identifier command word, ready mode}; mode 0 = always ready, 1 = one cycle in three
  localparam logic [39:0] SCEN [5] = '{
    {32'h0000_0040, 8'd0},
    {32'hABCD_0042, 8'd1},
    {32'h0000_0045, 8'd1},
    {32'hFFFF_FF43, 8'd0},
    {32'h0000_0099, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_pid = '0;
  logic        busy, done, rd_en, fl_valid;
  logic        fl_ready = 1'b0;
  logic [0:0]  rd_side;
  logic [1:0]  rd_way;
  logic [3:0]  rd_idx;
  logic [31:0] rd_hi = '0, rd_lo = '0, fl_vaddr;

  logic [31:0] hi_mem [N];
  logic [31:0] lo_mem [N];
  logic [31:0] exp_addr [N];
  int exp_n, got_n, rd_expect, done_cnt, cyc, tests, fails, mode;
  logic prev_stall, prev_done, finished;
  logic [31:0] prev_addr;

  always #5 clk = ~clk;

  tlb_pid_sweeper dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pid(start_pid),
    .busy(busy), .done(done), .rd_en(rd_en), .rd_side(rd_side),
    .rd_way(rd_way), .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_vaddr(fl_vaddr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // storage model: one-cycle read latency
  always @(posedge clk) begin
    if (rd_en) begin
      rd_hi <= hi_mem[{rd_side, rd_way, rd_idx}];
      rd_lo <= lo_mem[{rd_side, rd_way, rd_idx}];
    end
  end

  // ready driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      fl_ready = (mode == 0) ? 1'b1 : ((cyc % 3) == 2);
    end
  end

  // output monitor
  initial begin
    prev_stall = 1'b0;
    prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rd_en) begin
          chk(rd_expect < N && int'({rd_side, rd_way, rd_idx}) == rd_expect,
              "R3", "read address order", 32'({rd_side, rd_way, rd_idx}), 32'(rd_expect));
          chk(busy, "R3", "read while busy", 32'(busy), 32'd1);
          rd_expect++;
        end
        if (prev_stall)
          chk(fl_valid && fl_vaddr == prev_addr, "R6", "held request", fl_vaddr, prev_addr);
        if (fl_valid)
          chk(!rd_en, "R6", "no read while waiting", 32'(rd_en), 32'd0);
        if (fl_valid && fl_ready) begin
          chk(got_n < exp_n && fl_vaddr == exp_addr[got_n], "R5", "flush address",
              fl_vaddr, (got_n < exp_n) ? exp_addr[got_n] : 32'hDEAD_DEAD);
          got_n++;
        end
        if (prev_done)
          chk(!done, "R8", "done one cycle", 32'(done), 32'd0);
        if (done) begin
          done_cnt++;
          chk(!busy, "R9", "busy low with done", 32'(busy), 32'd0);
        end
        prev_stall = fl_valid && !fl_ready;
        prev_addr  = fl_vaddr;
        prev_done  = done;
      end
    end
  end

  // expected flush list from the match rule (R4): lo[3] valid, lo[4] global, hi[7:0] id
  task automatic build_expect(input logic [31:0] cmd);
    exp_n = 0;
    for (int n = 0; n < N; n++) begin
      if (lo_mem[n][3] && !lo_mem[n][4] && hi_mem[n][7:0] == cmd[7:0]) begin
        exp_addr[exp_n] = {hi_mem[n][31:13], 13'b0};
        exp_n++;
      end
    end
  endtask

  task automatic run_scan(input logic [31:0] cmd, input int md, input bit poke,
                          input bit timed);
    int edges;
    build_expect(cmd);
    got_n = 0; rd_expect = 0; done_cnt = 0; mode = md;
    @(negedge clk);
    start = 1'b1; start_pid = cmd;
    @(negedge clk);
    start = 1'b0; start_pid = 32'h0;
    chk(busy, "R2", "busy after start", 32'(busy), 32'd1);
    edges = 1;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; start_pid = 32'h44;
      @(negedge clk);
      start = 1'b0;
      edges += 21;
    end
    while (!done && edges < 5000) begin
      @(negedge clk);
      edges++;
      if (!done) chk(busy, "R9", "busy during sweep", 32'(busy), 32'd1);
    end
    chk(done, "R8", "done reached", 32'(done), 32'd1);
    if (timed)
      chk(edges - 1 == N + 2, "R8", "edges to done", 32'(edges - 1), 32'(N + 2));
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R8", "done count", 32'(done_cnt), 32'd1);
    chk(got_n == exp_n, "R4", "flush count", 32'(got_n), 32'(exp_n));
    chk(rd_expect == N, "R3", "read count", 32'(rd_expect), 32'(N));
    chk(!busy && !fl_valid, "R9", "idle after sweep", 32'({busy, fl_valid}), 32'd0);
  endtask

  initial begin
    tests = 0; fails = 0; cyc = 0; mode = 0; finished = 1'b0;
    for (int n = 0; n < N; n++) begin
      hi_mem[n] = {19'(n * 37 + 5), 5'b0, 8'(8'h40 + (n % 6))};
      lo_mem[n] = {19'(n * 11), 8'b0, (n % 5) == 0, (n % 4) != 1, 3'b101};
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_en && !fl_valid, "R1", "in reset",
        32'({busy, done, rd_en, fl_valid}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_en && !fl_valid, "R1", "after reset",
        32'({busy, done, rd_en, fl_valid}), 32'd0);

    // vector table walk (R2 upper bits masked, R4/R5 match and address, R6 back-pressure)
    foreach (SCEN[i]) begin
      run_scan(SCEN[i][39:8], int'(SCEN[i][7:0]), 1'b0, SCEN[i][39:8] == 32'h99);
    end

    // R7: second start in the middle of a sweep is ignored
    run_scan(32'h0000_0041, 1, 1'b1, 1'b0);

    // R2: idle start with only upper bits differing hits the same entries
    run_scan(32'h8000_0044, 0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule